// File: doc/BRIEF.md
# System Control Register Write Filter

This block holds a bank of thirty-two system-control registers. A five-bit index selects each one. Software-visible writes enter through one write port. Before a value is stored, it passes through a fixed per-register policy. The policy says whether the register exists, whether it can be written, whether it is 32 or 64 bits wide, and which bits must always read as zero.

A few registers also get special treatment on write:

- The interrupt-cause register takes only its two software-interrupt bits from a write.
- The entry-high register drops its fill bits.
- The status register never keeps its extended-addressing enables or its reverse-endian bit.

Reads are combinational through a second index.

After an accepted write, the block raises one-cycle pulses for the timer compare, counter, entry-high, status and cause registers. It also raises an interrupt re-evaluation pulse, so that neighbouring timer and interrupt logic can react. Three warning strobes flag three kinds of write: one that tried to set must-be-zero bits, a 64-bit write to a 32-bit register, and a write to an index that holds no register. All strobes and the stored value become visible on the same clock edge.

Top module: `sysctl_regfile`

## Requirements
- R1: Indices 8 and 15 are read-only. A write to either one leaves its value unchanged and raises no strobe. Index 15 holds the parameter ID_VALUE, and index 8 holds zero.
- R2: The must-be-zero mask is applied as follows. On every 32-bit register, bits 63:32 are must-be-zero. On index 0, bits 30:6 are also must-be-zero. On index 5, only bits 24:13 are writable. These bits are stored as zero, and warn_zero_p pulses when the written data had any of them set.
- R3: A write to the cause register (index 13) changes only bits 9:8. Every other cause bit keeps its previous value.
- R4: The entry-high register (index 10, 64-bit) stores only bits 63:62, 39:13 and 7:0. The fill bits 61:40 and 12:8 read back as zero, and clearing them raises no warning.
- R5: A write to the status register (index 12) stores bits 7:5 as zero, without a warning.
- R6: Status bit 25 (reverse endian) is stored as zero on every write.
- R7: A write with wr_is64 high to a writable 32-bit register pulses warn_size_p. The 64-bit writable registers are 2, 3, 4, 5, 10, 14, 20 and 30.
- R8: An accepted write pulses one output for one cycle after the write edge: index 11 pulses compare_wr_p, 9 pulses count_wr_p, 10 pulses entryhi_wr_p, 12 pulses status_wr_p and 13 pulses cause_wr_p. Writes to 12 or 13 also pulse irq_eval_p.
- R9: Indices 7, 21 to 25 and 31 hold no register. A write there pulses warn_invalid_p alone and stores nothing, and these indices read as zero.
- R10: rd_data shows the register selected by rd_idx combinationally. A written value is readable from the cycle after its write edge.
- R11: Reset is asynchronous active-low and is released after two clock edges. While reset is held or just after release, all strobes are low and registers hold zero, except index 15.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Write request, sampled at the rising edge |
| wr_idx | input | 5 | Register index to write |
| wr_data | input | 64 | Write data |
| wr_is64 | input | 1 | Write is a doubleword access |
| rd_idx | input | 5 | Register index to read |
| rd_data | output | 64 | Read data, combinational |
| compare_wr_p | output | 1 | Compare register was written |
| count_wr_p | output | 1 | Counter register was written |
| entryhi_wr_p | output | 1 | Entry-high register was written |
| status_wr_p | output | 1 | Status register was written |
| cause_wr_p | output | 1 | Cause register was written |
| irq_eval_p | output | 1 | Interrupt state needs re-evaluation |
| warn_zero_p | output | 1 | Write set must-be-zero bits |
| warn_size_p | output | 1 | 64-bit write to a 32-bit register |
| warn_invalid_p | output | 1 | Write to an undefined index |

## Verification
One write can trigger both the must-be-zero clean-up and the status-mode clean-up, together with the size warning. The bench provokes this with a doubleword write of all ones to the status register.

It then judges that write in the cycle after the edge, on two things:
- the stored value, which must be 0xFDFF_FF1F;
- four strobes high together: warn_zero_p, warn_size_p, status_wr_p and irq_eval_p.

A second case pairs the size and zero warnings with the counter pulse.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;
  localparam int XLEN = 64;
  localparam int NREG = 32;
  localparam int IDXW = $clog2(NREG);
  localparam int NSTB = 9;

  localparam int IDX_TLBIDX  = 0;
  localparam int IDX_PGMASK  = 5;
  localparam int IDX_BADADDR = 8;
  localparam int IDX_COUNT   = 9;
  localparam int IDX_ENTRYHI = 10;
  localparam int IDX_COMPARE = 11;
  localparam int IDX_STATUS  = 12;
  localparam int IDX_CAUSE   = 13;
  localparam int IDX_IDENT   = 15;

  localparam logic [XLEN-1:0] UPPER_HALF    = 64'hFFFF_FFFF_0000_0000;
  localparam logic [XLEN-1:0] CAUSE_SW_MASK = 64'h0000_0000_0000_0300;
  localparam logic [XLEN-1:0] ENTRYHI_KEEP  = 64'hC000_00FF_FFFF_E0FF;
  localparam logic [XLEN-1:0] STATUS_XMODE  = 64'h0000_0000_0000_00E0;
  localparam logic [XLEN-1:0] STATUS_REV    = 64'h0000_0000_0200_0000;
  localparam logic [XLEN-1:0] TLBIDX_ZERO   = 64'h0000_0000_7FFF_FFC0;
  localparam logic [XLEN-1:0] PGMASK_KEEP   = 64'h0000_0000_01FF_E000;

  typedef struct packed {
    logic            valid;
    logic            ro;
    logic            wide;
    logic [XLEN-1:0] zmask;
  } reg_policy_t;

  function automatic reg_policy_t policy_of(input int idx);
    reg_policy_t p;
    p.valid = 1'b1;
    p.ro    = 1'b0;
    p.wide  = 1'b0;
    p.zmask = UPPER_HALF;
    case (idx)
      7, 21, 22, 23, 24, 25, 31: begin
        p.valid = 1'b0;
        p.zmask = '0;
      end
      2, 3, 4, 10, 14, 20, 30: begin
        p.wide  = 1'b1;
        p.zmask = '0;
      end
      IDX_PGMASK: begin
        p.wide  = 1'b1;
        p.zmask = ~PGMASK_KEEP;
      end
      IDX_BADADDR: begin
        p.ro    = 1'b1;
        p.wide  = 1'b1;
        p.zmask = '0;
      end
      IDX_IDENT: begin
        p.ro    = 1'b1;
      end
      IDX_TLBIDX: begin
        p.zmask = UPPER_HALF | TLBIDX_ZERO;
      end
      default: ;
    endcase
    return p;
  endfunction
endpackage

// File: rtl/sysctl_rst_sync.sv
module sysctl_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n_in,
  output logic rst_n_out
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n_in) begin
    if (!rst_n_in) sync_q <= '0;
    else           sync_q <= {sync_q[STAGES-2:0], 1'b1};
  end

  assign rst_n_out = sync_q[STAGES-1];
endmodule

// File: rtl/sysctl_policy_dec.sv
module sysctl_policy_dec
  import sysctl_pkg::*;
(
  input  logic [IDXW-1:0] idx,
  output reg_policy_t     pol
);
  always_comb begin
    pol = policy_of(int'(idx));
  end
endmodule

// File: rtl/sysctl_wfilter.sv
module sysctl_wfilter
  import sysctl_pkg::*;
(
  input  logic            wr_en,
  input  logic [IDXW-1:0] wr_idx,
  input  logic [XLEN-1:0] wr_data,
  input  logic            wr_is64,
  input  reg_policy_t     pol,
  input  logic [XLEN-1:0] cur_val,
  output logic            accept,
  output logic [XLEN-1:0] nxt_val,
  output logic            warn_zero,
  output logic            warn_size,
  output logic            warn_invalid
);
  logic [XLEN-1:0] cleaned;

  always_comb begin
    accept       = wr_en & pol.valid & ~pol.ro;
    cleaned      = wr_data & ~pol.zmask;
    warn_zero    = accept & (|(wr_data & pol.zmask));
    warn_size    = accept & wr_is64 & ~pol.wide;
    warn_invalid = wr_en & ~pol.valid;
    case (int'(wr_idx))
      IDX_CAUSE:   nxt_val = (cur_val & ~CAUSE_SW_MASK) | (cleaned & CAUSE_SW_MASK);
      IDX_ENTRYHI: nxt_val = cleaned & ENTRYHI_KEEP;
      IDX_STATUS:  nxt_val = cleaned & ~(STATUS_XMODE | STATUS_REV);
      default:     nxt_val = cleaned;
    endcase
  end
endmodule

// File: rtl/sysctl_bank.sv
module sysctl_bank
  import sysctl_pkg::*;
#(
  parameter logic [XLEN-1:0] ID_VALUE = 64'h0000_0000_0000_0A40
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       we,
  input  logic [IDXW-1:0]            widx,
  input  logic [XLEN-1:0]            wdata,
  output logic [NREG-1:0][XLEN-1:0]  q_all
);
  for (genvar i = 0; i < NREG; i++) begin : g_reg
    localparam reg_policy_t P = policy_of(i);
    if (P.valid && !P.ro) begin : g_rw
      logic            en;
      logic [XLEN-1:0] q;
      assign en = we && (int'(widx) == i);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)  q <= '0;
        else if (en) q <= wdata;
      end
      assign q_all[i] = q;
    end else if (i == IDX_IDENT) begin : g_id
      assign q_all[i] = ID_VALUE;
    end else begin : g_zero
      assign q_all[i] = '0;
    end
  end
endmodule

// File: rtl/sysctl_regfile.sv
module sysctl_regfile
  import sysctl_pkg::*;
#(
  parameter logic [63:0] ID_VALUE = 64'h0000_0000_0000_0A40
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic [4:0]  wr_idx,
  input  logic [63:0] wr_data,
  input  logic        wr_is64,
  input  logic [4:0]  rd_idx,
  output logic [63:0] rd_data,
  output logic        compare_wr_p,
  output logic        count_wr_p,
  output logic        entryhi_wr_p,
  output logic        status_wr_p,
  output logic        cause_wr_p,
  output logic        irq_eval_p,
  output logic        warn_zero_p,
  output logic        warn_size_p,
  output logic        warn_invalid_p
);
  logic                      rst_n_q;
  reg_policy_t               wpol;
  logic [NREG-1:0][XLEN-1:0] q_all;
  logic                      accept;
  logic [XLEN-1:0]           nxt_val;
  logic                      wz, ws, winv;
  logic [NSTB-1:0]           stb_d, stb_q;

  sysctl_rst_sync #(.STAGES(2)) u_rst (
    .clk(clk), .rst_n_in(rst_n), .rst_n_out(rst_n_q)
  );

  sysctl_policy_dec u_pol (.idx(wr_idx), .pol(wpol));

  sysctl_wfilter u_filt (
    .wr_en(wr_en), .wr_idx(wr_idx), .wr_data(wr_data), .wr_is64(wr_is64),
    .pol(wpol), .cur_val(q_all[wr_idx]), .accept(accept), .nxt_val(nxt_val),
    .warn_zero(wz), .warn_size(ws), .warn_invalid(winv)
  );

  sysctl_bank #(.ID_VALUE(ID_VALUE)) u_bank (
    .clk(clk), .rst_n(rst_n_q), .we(accept), .widx(wr_idx),
    .wdata(nxt_val), .q_all(q_all)
  );

  assign rd_data = q_all[rd_idx];

  always_comb begin
    stb_d    = '0;
    stb_d[8] = accept && (int'(wr_idx) == IDX_COMPARE);
    stb_d[7] = accept && (int'(wr_idx) == IDX_COUNT);
    stb_d[6] = accept && (int'(wr_idx) == IDX_ENTRYHI);
    stb_d[5] = accept && (int'(wr_idx) == IDX_STATUS);
    stb_d[4] = accept && (int'(wr_idx) == IDX_CAUSE);
    stb_d[3] = stb_d[5] | stb_d[4];
    stb_d[2] = wz;
    stb_d[1] = ws;
    stb_d[0] = winv;
  end

  always_ff @(posedge clk or negedge rst_n_q) begin
    if (!rst_n_q) stb_q <= '0;
    else          stb_q <= stb_d;
  end

  assign {compare_wr_p, count_wr_p, entryhi_wr_p, status_wr_p, cause_wr_p,
          irq_eval_p, warn_zero_p, warn_size_p, warn_invalid_p} = stb_q;
endmodule

// File: rtl/sysctl_regfile_chk.sv
module sysctl_regfile_chk
  import sysctl_pkg::*;
(
  input logic                      clk,
  input logic                      rst_n,
  input logic                      wr_en,
  input logic [IDXW-1:0]           wr_idx,
  input logic [XLEN-1:0]           wr_data,
  input logic                      wr_is64,
  input logic [NREG-1:0][XLEN-1:0] q_all,
  input logic                      compare_wr_p,
  input logic                      count_wr_p,
  input logic                      entryhi_wr_p,
  input logic                      status_wr_p,
  input logic                      cause_wr_p,
  input logic                      irq_eval_p,
  input logic                      warn_zero_p,
  input logic                      warn_size_p,
  input logic                      warn_invalid_p
);
  // R1
  ro_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && (int'(wr_idx) == IDX_BADADDR || int'(wr_idx) == IDX_IDENT)
    |=> !(warn_zero_p || warn_size_p || warn_invalid_p || irq_eval_p));

  // R2
  tlbidx_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && int'(wr_idx) == IDX_TLBIDX && wr_data[6] |=> warn_zero_p);

  for (genvar i = 0; i < NREG; i++) begin : g_zm
    localparam reg_policy_t P = policy_of(i);
    if (P.valid && !P.ro) begin : g_chk
      // R2
      zmask_clean_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (q_all[i] & P.zmask) == '0);
    end
  end

  // R3
  cause_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && int'(wr_idx) == IDX_CAUSE
    |=> (q_all[IDX_CAUSE] & ~CAUSE_SW_MASK) == $past(q_all[IDX_CAUSE] & ~CAUSE_SW_MASK));

  // R4
  entryhi_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_all[IDX_ENTRYHI] & ~ENTRYHI_KEEP) == '0);

  // R5
  status_xmode_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_all[IDX_STATUS] & STATUS_XMODE) == '0);

  // R6
  status_rev_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (q_all[IDX_STATUS] & STATUS_REV) == '0);

  // R7
  count_size_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && wr_is64 && int'(wr_idx) == IDX_COUNT |=> warn_size_p);

  // R8
  status_eval_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && int'(wr_idx) == IDX_STATUS |=> status_wr_p && irq_eval_p);

  // R8
  pulse_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({compare_wr_p, count_wr_p, entryhi_wr_p, status_wr_p, cause_wr_p}));

  // R9
  invalid_warn_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en && int'(wr_idx) == 7 |=> warn_invalid_p && !irq_eval_p && !warn_zero_p);
endmodule

bind sysctl_regfile sysctl_regfile_chk u_chk (
  .clk(clk), .rst_n(rst_n_q), .wr_en(wr_en), .wr_idx(wr_idx),
  .wr_data(wr_data), .wr_is64(wr_is64), .q_all(q_all),
  .compare_wr_p(compare_wr_p), .count_wr_p(count_wr_p),
  .entryhi_wr_p(entryhi_wr_p), .status_wr_p(status_wr_p),
  .cause_wr_p(cause_wr_p), .irq_eval_p(irq_eval_p),
  .warn_zero_p(warn_zero_p), .warn_size_p(warn_size_p),
  .warn_invalid_p(warn_invalid_p)
);

// File: tb/sysctl_regfile_tb.sv
module sysctl_regfile_tb;
  localparam logic [63:0] ID = 64'h0000_0000_0000_0A40;
  localparam logic [8:0] S_NONE = 9'b0;
  localparam logic [8:0] S_CMP  = 9'b1_0000_0000;
  localparam logic [8:0] S_CNT  = 9'b0_1000_0000;
  localparam logic [8:0] S_EHI  = 9'b0_0100_0000;
  localparam logic [8:0] S_STA  = 9'b0_0010_0000;
  localparam logic [8:0] S_CAU  = 9'b0_0001_0000;
  localparam logic [8:0] S_IRQ  = 9'b0_0000_1000;
  localparam logic [8:0] S_WZ   = 9'b0_0000_0100;
  localparam logic [8:0] S_WS   = 9'b0_0000_0010;
  localparam logic [8:0] S_WI   = 9'b0_0000_0001;

  logic clk, rst_n, wr_en, wr_is64;
  logic [4:0] wr_idx, rd_idx;
  logic [63:0] wr_data, rd_data;
  logic compare_wr_p, count_wr_p, entryhi_wr_p, status_wr_p, cause_wr_p;
  logic irq_eval_p, warn_zero_p, warn_size_p, warn_invalid_p;
  int n_tests = 0;
  int n_fail  = 0;
  bit done = 0;

  sysctl_regfile #(.ID_VALUE(ID)) u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_idx(wr_idx),
    .wr_data(wr_data), .wr_is64(wr_is64), .rd_idx(rd_idx), .rd_data(rd_data),
    .compare_wr_p(compare_wr_p), .count_wr_p(count_wr_p),
    .entryhi_wr_p(entryhi_wr_p), .status_wr_p(status_wr_p),
    .cause_wr_p(cause_wr_p), .irq_eval_p(irq_eval_p),
    .warn_zero_p(warn_zero_p), .warn_size_p(warn_size_p),
    .warn_invalid_p(warn_invalid_p)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic logic [8:0] strobes();
    return {compare_wr_p, count_wr_p, entryhi_wr_p, status_wr_p, cause_wr_p,
            irq_eval_p, warn_zero_p, warn_size_p, warn_invalid_p};
  endfunction

  task automatic check(string req, logic [63:0] act, logic [63:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic read_chk(string req, logic [4:0] idx, logic [63:0] exp);
    rd_idx = idx;
    #1;
    check(req, rd_data, exp);
  endtask

  // Drive a write at a falling edge; after the next rising edge, check strobes and storage.
  task automatic wr(string req, logic [4:0] idx, logic [63:0] d, logic w64,
                    logic [8:0] exp_stb, logic [63:0] exp_val);
    @(negedge clk);
    wr_en = 1'b1; wr_idx = idx; wr_data = d; wr_is64 = w64;
    @(negedge clk);
    wr_en = 1'b0;
    check(req, {55'b0, strobes()}, {55'b0, exp_stb});
    read_chk(req, idx, exp_val);
  endtask

  task automatic t_reset();
    check("R11 strobes", {55'b0, strobes()}, 64'b0);
    read_chk("R11 ident", 5'd15, ID);
    read_chk("R11 status", 5'd12, 64'h0);
  endtask

  task automatic t_readonly();
    wr("R1 ident", 5'd15, '1, 1'b1, S_NONE, ID);
    wr("R1 badaddr", 5'd8, 64'h1234, 1'b1, S_NONE, 64'h0);
  endtask

  task automatic t_zero();
    wr("R2 tlbidx ok", 5'd0, 64'h8000_003F, 1'b0, S_NONE, 64'h8000_003F);
    wr("R2 tlbidx bad", 5'd0, 64'h0000_0040, 1'b0, S_WZ, 64'h0);
    wr("R2 pgmask ok", 5'd5, 64'h01FF_E000, 1'b1, S_NONE, 64'h01FF_E000);
    wr("R2 pgmask bad", 5'd5, 64'h0000_0000_0200_1000, 1'b1, S_WZ, 64'h0);
  endtask

  task automatic t_cause();
    wr("R3 cause ones", 5'd13, '1, 1'b0, S_CAU | S_IRQ | S_WZ, 64'h300);
    wr("R3 cause one bit", 5'd13, 64'h0000_0000_0000_FD00, 1'b0, S_CAU | S_IRQ, 64'h100);
  endtask

  task automatic t_entryhi();
    wr("R4 entryhi", 5'd10, '1, 1'b1, S_EHI, 64'hC000_00FF_FFFF_E0FF);
  endtask

  task automatic t_status();
    wr("R5 status xmode", 5'd12, 64'h0000_00E0, 1'b0, S_STA | S_IRQ, 64'h0);
    wr("R6 status rev", 5'd12, 64'h0200_0001, 1'b0, S_STA | S_IRQ, 64'h1);
  endtask

  task automatic t_size();
    wr("R7 count 64", 5'd9, 64'h1_0000_0005, 1'b1, S_CNT | S_WZ | S_WS, 64'h5);
    wr("R7 wide reg", 5'd20, '1, 1'b1, S_NONE, '1);
  endtask

  task automatic t_pulses();
    wr("R8 compare", 5'd11, 64'h1234, 1'b0, S_CMP, 64'h1234);
    @(negedge clk);
    check("R8 one cycle", {55'b0, strobes()}, 64'b0);
  endtask

  task automatic t_invalid();
    wr("R9 idx7", 5'd7, 64'hFF, 1'b0, S_WI, 64'h0);
    wr("R9 idx31", 5'd31, 64'hFF, 1'b1, S_WI, 64'h0);
  endtask

  task automatic t_readcomb();
    read_chk("R10 read 20", 5'd20, '1);
    read_chk("R10 read 11", 5'd11, 64'h1234);
    read_chk("R10 read 15", 5'd15, ID);
  endtask

  task automatic t_combined();
    wr("R5 R6 R7 combined", 5'd12, '1, 1'b1, S_STA | S_IRQ | S_WZ | S_WS, 64'hFDFF_FF1F);
  endtask

  initial begin
    rst_n = 1'b0; wr_en = 1'b0; wr_idx = '0; wr_data = '0; wr_is64 = 1'b0; rd_idx = '0;
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    t_reset();
    t_readonly();
    t_zero();
    t_cause();
    t_entryhi();
    t_status();
    t_size();
    t_pulses();
    t_invalid();
    t_readcomb();
    t_combined();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule